// File: doc/BRIEF.md
# Keyed Low-Frequency Clock Control Register

This block is the 32-bit control and status register of a low-frequency clock subsystem. Software reaches it over a plain synchronous register bus: a write enable, four byte enables, write data and combinational read data. The register picks the low-frequency source (internal RC or external 32.768 kHz crystal) and the timer source (the low-frequency source or a divided 24 MHz clock). It also holds the crystal drive level, the crystal enable and the two controls for automatic fallback. Two read-only flags report calendar writes that have not yet been committed.

The two source-select bits are guarded by a key. A write changes them only when the upper half-word of that same write equals 0x16AA. When fallback is allowed, a pulse on the oscillator-loss input clears the crystal select in hardware. Any change of either select bit raises a single-cycle notice for the downstream clock multiplexer.

Top module: `lfclk_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00004010: crystal enable (bit 4) and fallback select enable (bit 14) are 1, and every other bit is 0.
- R2: Bit 0 (low-frequency source, 1 = crystal) and bit 1 (timer source, 1 = divided 24 MHz) take the written byte-0 value only when byte enables 3 and 2 are both set and write data bits 31:16 equal 0x16AA. Any other write leaves both bits unchanged.
- R3: Bits 3:2 (crystal drive), bit 4 (crystal enable), bit 14 (fallback select enable) and bit 15 (auto-switch disable, 1 = disabled) are ordinary read/write bits. Each one is written when its byte enable is set, and no key is needed.
- R4: Bits 31:16, bits 6:5 and bits 13:9 always read as 0, and writes to them have no effect.
- R5: A cycle with the day-write-issued strobe sets bit 7. A cycle with the day-write-done strobe and no issue strobe clears it. Bus writes never change bit 7.
- R6: Bit 8 behaves like bit 7, driven by the time-of-day issue and done strobes. When the issue and done strobes arrive in the same cycle, the flag ends up set.
- R7: An oscillator-loss pulse while bit 14 is 1 and bit 15 is 0 clears bit 0 on the next edge. If bit 14 is 0 or bit 15 is 1, bit 0 is unaffected.
- R8: If a fallback and a keyed write that sets bit 0 happen in the same cycle, bit 0 ends up 0.
- R9: The source-change output is high for exactly the one cycle after bit 0 or bit 1 changes value, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe |
| busBe | input | 4 | Byte enables for the write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Current register value |
| oscLost | input | 1 | Oscillator-loss pulse |
| dayWrIssue | input | 1 | Day register write issued |
| dayWrDone | input | 1 | Day register write committed |
| hmsWrIssue | input | 1 | Time-of-day write issued |
| hmsWrDone | input | 1 | Time-of-day write committed |
| srcChanged | output | 1 | One-cycle pulse when a source select changes |
| lfSrcXtal | output | 1 | Current bit 0 |
| timerSrcDiv | output | 1 | Current bit 1 |

## Verification
Read data is combinational from the register state, so a bad internal bit shows on busRdata in the cycle right after the edge that stored it. A select bit that flips when it should not, such as a key accepted wrongly or a fallback that ignores its enables, also raises srcChanged one cycle later. This lets a stray change be seen even when the bench is not reading the bit. The flags for pending calendar writes show their set and clear order on the edge after each strobe.

// File: rtl/lfclk_ctrl_pkg.sv
package lfclk_ctrl_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W = DATA_W / 8;
  localparam logic [15:0] UNLOCK_KEY = 16'h16AA;

  localparam int B_LFSRC = 0;
  localparam int B_TMRSRC = 1;
  localparam int B_DRV_LO = 2;
  localparam int B_XTALEN = 4;
  localparam int B_DAYPEND = 7;
  localparam int B_HMSPEND = 8;
  localparam int B_FBSEL = 14;
  localparam int B_FBOFF = 15;

  localparam logic [DATA_W-1:0] RESET_VAL = 32'h0000_4010;

  typedef struct packed {
    logic keyedWr;   // valid keyed write this cycle
    logic byte0Wr;   // plain write of byte 0
    logic byte1Wr;   // plain write of byte 1
    logic fallback;  // hardware clear of the crystal select
    logic daySet;
    logic dayClr;
    logic hmsSet;
    logic hmsClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/lfclk_ctrl_fsm.sv
module lfclk_ctrl_fsm
  import lfclk_ctrl_pkg::*;
(
  input  logic              busWe,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              oscLost,
  input  logic              fbSelEn,
  input  logic              fbDisable,
  input  logic              dayWrIssue,
  input  logic              dayWrDone,
  input  logic              hmsWrIssue,
  input  logic              hmsWrDone,
  output ctrlStrobes_t      strobes
);
  logic keyMatch;

  always_comb begin
    keyMatch = busBe[3] && busBe[2] && (busWdata[31:16] == UNLOCK_KEY);
    strobes.keyedWr  = busWe && busBe[0] && keyMatch;
    strobes.byte0Wr  = busWe && busBe[0];
    strobes.byte1Wr  = busWe && busBe[1];
    strobes.fallback = oscLost && fbSelEn && !fbDisable;
    strobes.daySet   = dayWrIssue;
    strobes.dayClr   = dayWrDone && !dayWrIssue;
    strobes.hmsSet   = hmsWrIssue;
    strobes.hmsClr   = hmsWrDone && !hmsWrIssue;
  end
endmodule

// File: rtl/lfclk_ctrl_dp.sv
module lfclk_ctrl_dp
  import lfclk_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] regValue,
  output logic              srcChanged
);
  logic       lfSrc, tmrSrc, xtalEn, fbSel, fbOff, dayPend, hmsPend;
  logic [1:0] drive;
  logic       lfSrcNext, tmrSrcNext;

  always_comb begin
    lfSrcNext  = lfSrc;
    tmrSrcNext = tmrSrc;
    if (strobes.keyedWr) begin
      lfSrcNext  = busWdata[B_LFSRC];
      tmrSrcNext = busWdata[B_TMRSRC];
    end
    if (strobes.fallback) lfSrcNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfSrc      <= RESET_VAL[B_LFSRC];
      tmrSrc     <= RESET_VAL[B_TMRSRC];
      drive      <= RESET_VAL[B_DRV_LO+:2];
      xtalEn     <= RESET_VAL[B_XTALEN];
      fbSel      <= RESET_VAL[B_FBSEL];
      fbOff      <= RESET_VAL[B_FBOFF];
      dayPend    <= 1'b0;
      hmsPend    <= 1'b0;
      srcChanged <= 1'b0;
    end else begin
      lfSrc      <= lfSrcNext;
      tmrSrc     <= tmrSrcNext;
      srcChanged <= (lfSrcNext != lfSrc) || (tmrSrcNext != tmrSrc);
      if (strobes.byte0Wr) begin
        drive  <= busWdata[B_DRV_LO+:2];
        xtalEn <= busWdata[B_XTALEN];
      end
      if (strobes.byte1Wr) begin
        fbSel <= busWdata[B_FBSEL];
        fbOff <= busWdata[B_FBOFF];
      end
      if (strobes.daySet) dayPend <= 1'b1;
      else if (strobes.dayClr) dayPend <= 1'b0;
      if (strobes.hmsSet) hmsPend <= 1'b1;
      else if (strobes.hmsClr) hmsPend <= 1'b0;
    end
  end

  always_comb begin
    regValue             = '0;
    regValue[B_LFSRC]    = lfSrc;
    regValue[B_TMRSRC]   = tmrSrc;
    regValue[B_DRV_LO+:2] = drive;
    regValue[B_XTALEN]   = xtalEn;
    regValue[B_DAYPEND]  = dayPend;
    regValue[B_HMSPEND]  = hmsPend;
    regValue[B_FBSEL]    = fbSel;
    regValue[B_FBOFF]    = fbOff;
  end
endmodule

// File: rtl/lfclk_ctrl_reg.sv
module lfclk_ctrl_reg
  import lfclk_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              oscLost,
  input  logic              dayWrIssue,
  input  logic              dayWrDone,
  input  logic              hmsWrIssue,
  input  logic              hmsWrDone,
  output logic              srcChanged,
  output logic              lfSrcXtal,
  output logic              timerSrcDiv
);
  ctrlStrobes_t strobes;
  logic [DATA_W-1:0] regValue;

  lfclk_ctrl_fsm u_ctrl (
    .busWe(busWe), .busBe(busBe), .busWdata(busWdata), .oscLost(oscLost),
    .fbSelEn(regValue[B_FBSEL]), .fbDisable(regValue[B_FBOFF]),
    .dayWrIssue(dayWrIssue), .dayWrDone(dayWrDone),
    .hmsWrIssue(hmsWrIssue), .hmsWrDone(hmsWrDone), .strobes(strobes)
  );

  lfclk_ctrl_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .regValue(regValue), .srcChanged(srcChanged)
  );

  assign busRdata    = regValue;
  assign lfSrcXtal   = regValue[B_LFSRC];
  assign timerSrcDiv = regValue[B_TMRSRC];
endmodule

// File: rtl/lfclk_ctrl_reg_chk.sv
module lfclk_ctrl_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWe,
  input logic [3:0]  busBe,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        oscLost,
  input logic        dayWrIssue,
  input logic        dayWrDone,
  input logic        srcChanged
);
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata[31:16] == 16'h0) && (busRdata[6:5] == 2'b0) && (busRdata[13:9] == 5'h0));

  p_nokey_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(busWe && busBe[3] && busBe[2] && busWdata[31:16] == 16'h16AA) && !oscLost)
      |=> $stable(busRdata[1:0]));

  p_fallback_r7: assert property (@(posedge clk) disable iff (!rstN)
    (oscLost && busRdata[14] && !busRdata[15]) |=> !busRdata[0]);

  p_day_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    dayWrIssue |=> busRdata[7]);

  p_day_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dayWrDone && !dayWrIssue) |=> !busRdata[7]);

  p_change_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata[1:0] != $past(busRdata[1:0])) |-> srcChanged);
endmodule

bind lfclk_ctrl_reg lfclk_ctrl_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busBe(busBe), .busWdata(busWdata),
  .busRdata(busRdata), .oscLost(oscLost), .dayWrIssue(dayWrIssue),
  .dayWrDone(dayWrDone), .srcChanged(srcChanged)
);

// File: tb/lfclk_ctrl_reg_tb.sv
module lfclk_ctrl_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RW_MASK = 32'h0000_C01F;

  logic clk = 0, rstN = 0;
  logic busWe = 0;
  logic [3:0] busBe = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic oscLost = 0, dayWrIssue = 0, dayWrDone = 0, hmsWrIssue = 0, hmsWrDone = 0;
  logic srcChanged, lfSrcXtal, timerSrcDiv;
  int nChecks = 0, nFails = 0;
  logic [31:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfclk_ctrl_reg u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busBe(busBe), .busWdata(busWdata),
    .busRdata(busRdata), .oscLost(oscLost), .dayWrIssue(dayWrIssue),
    .dayWrDone(dayWrDone), .hmsWrIssue(hmsWrIssue), .hmsWrDone(hmsWrDone),
    .srcChanged(srcChanged), .lfSrcXtal(lfSrcXtal), .timerSrcDiv(timerSrcDiv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply inputs after the falling edge, let one rising edge pass, sample at next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    busWe = 0; busBe = 0; busWdata = 0; oscLost = 0;
    dayWrIssue = 0; dayWrDone = 0; hmsWrIssue = 0; hmsWrDone = 0;
  endtask

  function automatic logic [31:0] modelWrite(input logic [31:0] m, input logic [3:0] be,
                                             input logic [31:0] d);
    logic [31:0] r = m;
    if (be[0]) begin
      r[4:2] = d[4:2];
      if (be[3] && be[2] && d[31:16] == 16'h16AA) r[1:0] = d[1:0];
    end
    if (be[1]) r[15:14] = d[15:14];
    return r;
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        check("R1 reset value", busRdata, 32'h0000_4010);
        check("R9 idle after reset", {31'b0, srcChanged}, 0);
        model = 32'h0000_4010;

        // R2/R3/R4 sweep: byte enables x key choices x data patterns
        for (int be = 0; be < 16; be++) begin
          for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < 4; p++) begin
              logic [31:0] d;
              logic [31:0] prev;
              d = {16'h0, 16'hFFFF} ^ {16'h0, 4'(p) * 4'h5, 4'(p), 4'(p) * 4'h3, 4'(p) * 4'h7};
              d[31:16] = (k == 0) ? 16'h16AA : (k == 1) ? 16'h16AB : 16'h0000;
              prev = model;
              busWe = 1; busBe = 4'(be); busWdata = d;
              step();
              model = modelWrite(model, 4'(be), d);
              check("R2 R3 R4 keyed write sweep", busRdata, model);
              check("R9 change pulse", {31'b0, srcChanged},
                    {31'b0, model[1:0] != prev[1:0]});
            end
          end
        end
        check("R2 select pins", {30'b0, timerSrcDiv, lfSrcXtal}, {30'b0, model[1:0]});

        // R7: fallback enabled
        busWe = 1; busBe = 4'hF; busWdata = 32'h16AA_4011; step();
        model = 32'h0000_4011;
        check("R7 setup", busRdata, model);
        oscLost = 1; step();
        check("R7 fallback clears bit0", busRdata, 32'h0000_4010);
        check("R9 pulse on fallback", {31'b0, srcChanged}, 1);
        step();
        check("R9 pulse one cycle", {31'b0, srcChanged}, 0);

        // R7: bit15 disables
        busWe = 1; busBe = 4'hF; busWdata = 32'h16AA_C011; step();
        oscLost = 1; step();
        check("R7 disable bit15 blocks", busRdata, 32'h0000_C011);
        // R7: bit14 clear blocks
        busWe = 1; busBe = 4'hF; busWdata = 32'h16AA_0011; step();
        oscLost = 1; step();
        check("R7 bit14 clear blocks", busRdata, 32'h0000_0011);

        // R8: fallback vs keyed write setting bit0
        busWe = 1; busBe = 4'hF; busWdata = 32'h16AA_4010; step();
        check("R8 setup", busRdata, 32'h0000_4010);
        busWe = 1; busBe = 4'hF; busWdata = 32'h16AA_4011; oscLost = 1; step();
        check("R8 fallback wins", busRdata, 32'h0000_4010);
        check("R9 no change no pulse", {31'b0, srcChanged}, 0);

        // R5 / R6 pending flags
        dayWrIssue = 1; step();
        check("R5 day set", {31'b0, busRdata[7]}, 1);
        busWe = 1; busBe = 4'hF; busWdata = 32'h0000_0000; step();
        check("R5 bus write ignored", {31'b0, busRdata[7]}, 1);
        dayWrDone = 1; step();
        check("R5 day clear", {31'b0, busRdata[7]}, 0);
        dayWrIssue = 1; dayWrDone = 1; step();
        check("R5 set wins", {31'b0, busRdata[7]}, 1);
        busWe = 1; busBe = 4'hF; busWdata = 32'h0000_0180; step();
        check("R6 bus cannot set", {31'b0, busRdata[8]}, 0);
        hmsWrIssue = 1; step();
        check("R6 hms set", {31'b0, busRdata[8]}, 1);
        hmsWrIssue = 1; hmsWrDone = 1; step();
        check("R6 set wins", {31'b0, busRdata[8]}, 1);
        hmsWrDone = 1; step();
        check("R6 hms clear", {31'b0, busRdata[8]}, 0);
        check("R5 day unaffected", {31'b0, busRdata[7]}, 1);
        check("R4 mask", busRdata & ~(RW_MASK | 32'h180), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule